// File: doc/BRIEF.md
# Iterative 64-bit Feistel Block Cipher Core

This core encrypts or decrypts a single 64-bit block under a 256-bit key with a 32-round Feistel network of the GOST 28147-89 kind. It works in electronic-codebook fashion. Each block is handled on its own, and nothing carries over from one block to the next. One round datapath runs once per clock, so a block costs 32 cycles. That datapath is the only round logic, and both directions use it. They differ only in the order in which the eight 32-bit subkeys are selected.

A caller sets up the key, the block, the direction and the substitution-set choice, then pulses the start strobe. The core captures all of these in that cycle and raises its busy flag. It pulses done once the last round is in the result register. Two fixed substitution-table sets are built in, and the caller picks one per block through a select input.

Top module: `gost_ecb_core`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `done` are 0 and `dout` is all zeros.
- R2: A start seen while idle is taken at that clock edge. `busy` is 1 for the next 32 cycles. `done` is 1 in the cycle that follows the 32nd clock edge after the accepting edge, and `busy` is 0 in that same cycle.
- R3: `done` is high for exactly one cycle per block, and never while `busy` is high.
- R4: Encryption works as follows. The left half is `din[63:32]` and the right half is `din[31:0]`. Subkey Kn is `key[32n+31:32n]`. In each round, the right half is added to the subkey modulo 2^32. Nibble i of the sum (bits 4i+3:4i) then passes through S-box i of the chosen set. The result is rotated left by 11, and XORed into the left half. Rounds 1 to 24 use K0..K7 three times over, and rounds 25 to 32 use K7..K0.
- R5: Decryption (`decrypt`=1) uses the same round. Rounds 1 to 8 use K0..K7, and rounds 9 to 32 use K7..K0 three times over.
- R6: After every round except the last, the old right half becomes the new left half and the XOR result becomes the new right half. The last round does not swap the halves, so `dout` = {XOR result, right half}.
- R7: `sbox_sel`=0 selects the first table set and `sbox_sel`=1 the second. Each S-box is a 16-entry nibble permutation, and the choice can differ from one block to the next.
- R8: Decrypting a block that this core encrypted, with the same key and set, gives back the original plaintext.
- R9: A start raised while `busy` is high is ignored. It produces no extra `done`, and the block in flight finishes on time with its own result.
- R10: `key`, `din`, `decrypt` and `sbox_sel` count only in the cycle a start is accepted. Changing them while busy does not change the result.
- R11: `dout` changes only in the cycle `done` rises and holds its value until the next block completes.
- R12: A start raised in the cycle that `done` is high is accepted, so blocks can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe; captures the inputs when idle |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| sbox_sel | input | 1 | Substitution-table set select |
| key | input | 256 | Cipher key, subkey Kn at bits 32n+31:32n |
| din | input | 64 | Input block |
| dout | output | 64 | Result block |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while rounds are running |

## Verification
The bench drives every input away from its captured value as soon as a start is taken. A core that reads the live key, data, direction or set select after the start then gives a wrong block, not the one the scoreboard expects. It raises start while a block is still in flight. A core that reloads at that point either finishes late or produces a second, unexpected done. It also raises start in the very cycle done arrives. A core that needs an idle gap between blocks would drop that block or finish it a cycle late. Both table sets are run in both directions, and encryption is followed by decryption of the core's own output. A wrong subkey order, a missing final-round swap rule, a wrong rotate amount or a swapped table shows up as a mismatched block.

// File: rtl/gost_pkg.sv
package gost_pkg;

    localparam int BLK_W    = 64;
    localparam int HALF_W   = BLK_W / 2;
    localparam int NSUB     = 8;
    localparam int KEY_W    = NSUB * HALF_W;
    localparam int NROUND   = 32;
    localparam int NIB_W    = 4;
    localparam int NSBOX    = HALF_W / NIB_W;
    localparam int ROT_L    = 11;
    localparam int RND_W    = $clog2(NROUND);
    localparam int SUBIDX_W = $clog2(NSUB);
    localparam int FWD_LEN  = NROUND - NSUB;   // rounds run in ascending key order when encrypting
    localparam int TBL_W    = NIB_W * (1 << NIB_W);

    typedef struct packed {
        logic [HALF_W-1:0] left;
        logic [HALF_W-1:0] right;
    } blk_t;

    typedef enum logic {
        DIR_ENC = 1'b0,
        DIR_DEC = 1'b1
    } dir_e;

    typedef enum logic {
        SET_FIRST  = 1'b0,
        SET_SECOND = 1'b1
    } tset_e;

    // Each row: entry 0 is the leftmost hex digit, entry 15 the rightmost.
    localparam logic [TBL_W-1:0] TABLES_A [NSBOX] = '{
        64'h4A92D80E6B1C7F53,
        64'hEB4C6DFA23810759,
        64'h581DA342EFC7609B,
        64'h7DA1089FE46CB253,
        64'h6C715FD84A9E03B2,
        64'h4BA0721D36859CFE,
        64'hDB413F590AE7682C,
        64'h1FD057A4923E6B8C
    };

    localparam logic [TBL_W-1:0] TABLES_B [NSBOX] = '{
        64'h96328B17A4EFC0D5,
        64'h37E98AF0526CB4D1,
        64'hE462B3D8CF5A0719,
        64'hE7ACD13902B4F856,
        64'hB5198DF0E423C7A6,
        64'h3ADC120B75948FE6,
        64'h1D297A608C45F3BE,
        64'hBAF50CE8623917D4
    };

    function automatic logic [NIB_W-1:0] sbox_nib(tset_e set, int pos, logic [NIB_W-1:0] nib);
        logic [TBL_W-1:0] row;
        row = (set == SET_SECOND) ? TABLES_B[pos] : TABLES_A[pos];
        return row[((1 << NIB_W) - 1 - int'(nib)) * NIB_W +: NIB_W];
    endfunction

    function automatic logic [HALF_W-1:0] rotl(logic [HALF_W-1:0] x);
        return {x[HALF_W-ROT_L-1:0], x[HALF_W-1:HALF_W-ROT_L]};
    endfunction

    // Subkey slot for a zero-based round in the given direction.
    function automatic logic [SUBIDX_W-1:0] sub_idx(dir_e d, logic [RND_W-1:0] rnd);
        logic [SUBIDX_W-1:0] lo;
        logic                ascend;
        lo = rnd[SUBIDX_W-1:0];
        if (d == DIR_ENC) ascend = (rnd < RND_W'(FWD_LEN));
        else              ascend = (rnd < RND_W'(NSUB));
        return ascend ? lo : ~lo;
    endfunction

endpackage

// File: rtl/gost_keysched.sv
module gost_keysched
    import gost_pkg::*;
(
    input  logic [KEY_W-1:0]  key_q,
    input  dir_e              dir_q,
    input  logic [RND_W-1:0]  rnd,
    output logic [HALF_W-1:0] subkey
);

    logic [HALF_W-1:0]   slot [NSUB];
    logic [SUBIDX_W-1:0] pick;

    for (genvar g = 0; g < NSUB; g++) begin : g_slot
        assign slot[g] = key_q[g*HALF_W +: HALF_W];
    end

    always_comb begin
        pick   = sub_idx(dir_q, rnd);
        subkey = slot[pick];
    end

endmodule

// File: rtl/gost_round.sv
module gost_round
    import gost_pkg::*;
(
    input  blk_t              blk_in,
    input  logic [HALF_W-1:0] subkey,
    input  tset_e             set_q,
    input  logic              last,
    output blk_t              blk_out
);

    logic [HALF_W-1:0] sum;
    logic [HALF_W-1:0] subst;
    logic [HALF_W-1:0] mixed;

    assign sum = blk_in.right + subkey;

    for (genvar g = 0; g < NSBOX; g++) begin : g_sbox
        assign subst[g*NIB_W +: NIB_W] = sbox_nib(set_q, g, sum[g*NIB_W +: NIB_W]);
    end

    assign mixed = blk_in.left ^ rotl(subst);

    always_comb begin
        if (last) begin
            blk_out.left  = mixed;
            blk_out.right = blk_in.right;
        end else begin
            blk_out.left  = blk_in.right;
            blk_out.right = mixed;
        end
    end

endmodule

// File: rtl/gost_ctrl.sv
module gost_ctrl
    import gost_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             load,
    output logic             last,
    output logic [RND_W-1:0] rnd
);

    localparam logic [RND_W-1:0] RND_LAST = RND_W'(NROUND - 1);

    assign load = start && !busy;
    assign last = (rnd == RND_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            rnd  <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy <= 1'b1;
                rnd  <= '0;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    rnd <= rnd + 1'b1;
                end
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                       // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                       // R3
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy && last));                                         // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && rnd == $past(rnd) + 1'b1));               // R9

endmodule

// File: rtl/gost_ecb_core.sv
module gost_ecb_core
    import gost_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              decrypt,
    input  logic              sbox_sel,
    input  logic [KEY_W-1:0]  key,
    input  logic [BLK_W-1:0]  din,
    output logic [BLK_W-1:0]  dout,
    output logic              done,
    output logic              busy
);

    logic [KEY_W-1:0]  key_q;
    dir_e              dir_q;
    tset_e             set_q;
    blk_t              state_q;
    blk_t              next_blk;
    logic [HALF_W-1:0] subkey;
    logic              load;
    logic              last;
    logic [RND_W-1:0]  rnd;
    logic [BLK_W-1:0]  result_q;

    gost_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .last  (last),
        .rnd   (rnd)
    );

    gost_keysched u_ks (
        .key_q  (key_q),
        .dir_q  (dir_q),
        .rnd    (rnd),
        .subkey (subkey)
    );

    gost_round u_round (
        .blk_in  (state_q),
        .subkey  (subkey),
        .set_q   (set_q),
        .last    (last),
        .blk_out (next_blk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q    <= '0;
            dir_q    <= DIR_ENC;
            set_q    <= SET_FIRST;
            state_q  <= '0;
            result_q <= '0;
        end else if (load) begin
            key_q   <= key;
            dir_q   <= dir_e'(decrypt);
            set_q   <= tset_e'(sbox_sel);
            state_q <= blk_t'(din);
        end else if (busy) begin
            state_q <= next_blk;
            if (last) result_q <= next_blk;
        end
    end

    assign dout = result_q;

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result_q));                                          // R11
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable({key_q, dir_q, set_q}));             // R10

endmodule

// File: tb/sim_gost_ecb_core.sv
module sim_gost_ecb_core;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         decrypt = 1'b0;
    logic         sbox_sel = 1'b0;
    logic [255:0] key = '0;
    logic [63:0]  din = '0;
    logic [63:0]  dout;
    logic         done;
    logic         busy;

    always #2 clk = ~clk;

    gost_ecb_core u0 (
        .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .sbox_sel(sbox_sel),
        .key(key), .din(din), .dout(dout), .done(done), .busy(busy)
    );

    localparam logic [63:0] TA [8] = '{
        64'h4A92D80E6B1C7F53, 64'hEB4C6DFA23810759, 64'h581DA342EFC7609B, 64'h7DA1089FE46CB253,
        64'h6C715FD84A9E03B2, 64'h4BA0721D36859CFE, 64'hDB413F590AE7682C, 64'h1FD057A4923E6B8C
    };
    localparam logic [63:0] TB [8] = '{
        64'h96328B17A4EFC0D5, 64'h37E98AF0526CB4D1, 64'hE462B3D8CF5A0719, 64'hE7ACD13902B4F856,
        64'hB5198DF0E423C7A6, 64'h3ADC120B75948FE6, 64'h1D297A608C45F3BE, 64'hBAF50CE8623917D4
    };

    function automatic logic [31:0] ref_f(logic [31:0] x, logic s);
        logic [31:0] o;
        logic [63:0] row;
        for (int i = 0; i < 8; i++) begin
            row = s ? TB[i] : TA[i];
            o[4*i +: 4] = row[60 - 4*int'(x[4*i +: 4]) +: 4];
        end
        return {o[20:0], o[31:21]};
    endfunction

    function automatic logic [63:0] ref_cipher(logic [255:0] k, logic [63:0] d, logic dec, logic s);
        logic [31:0] l, r, t;
        l = d[63:32];
        r = d[31:0];
        for (int n = 0; n < 32; n++) begin
            int ki;
            if (dec) ki = (n < 8)  ? n     : 7 - (n % 8);
            else     ki = (n < 24) ? n % 8 : 7 - (n % 8);
            t = l ^ ref_f(r + k[32*ki +: 32], s);
            if (n == 31) l = t;
            else begin l = r; r = t; end
        end
        return {l, r};
    endfunction

    typedef struct {
        logic [63:0] exp;
        int          due;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a block completes.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R9 unexpected done", dout, 64'h0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(dout === it.exp, it.tag, dout, it.exp);
                check(cyc == it.due, "R2 latency", 64'(cyc), 64'(it.due));
                check(busy === 1'b0, "R3 busy low at done", 64'(busy), 64'h0);
            end
        end
    end

    // Driver: called just after a negedge; start is taken at the next posedge.
    task automatic issue_exp(logic [255:0] k, logic [63:0] d, logic dec, logic s,
                             logic [63:0] exp, string tag);
        item_t it;
        key = k; din = d; decrypt = dec; sbox_sel = s; start = 1'b1;
        it.exp = exp;
        it.due = cyc + 33;
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        start = 1'b0;
        key = ~k; din = ~d; decrypt = ~dec; sbox_sel = ~s;   // R10: inputs move after capture
    endtask

    task automatic issue(logic [255:0] k, logic [63:0] d, logic dec, logic s, string tag);
        issue_exp(k, d, dec, s, ref_cipher(k, d, dec, s), tag);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    localparam logic [255:0] KEY1 = 256'h0123456789ABCDEF_FEDCBA9876543210_0F1E2D3C4B5A6978_8796A5B4C3D2E1F0;
    localparam logic [255:0] KEY2 = 256'hDEADBEEF00000001_13579BDF2468ACE0_FFFFFFFF00000000_55AA55AA33CC33CC;
    localparam logic [63:0]  PT1  = 64'h0011223344556677;
    localparam logic [63:0]  PT2  = 64'hFFFFFFFF00000001;

    initial begin
        logic [63:0] ct;
        logic [63:0] held;
        repeat (4) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {62'h0, busy, done}, 64'h0);
        check(dout === 64'h0, "R1 dout in reset", dout, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && dout === 64'h0, "R1 after reset", dout, 64'h0);

        issue(KEY1, PT1, 1'b0, 1'b0, "R4 R6 R7 enc set0");
        repeat (5) @(negedge clk);
        check(busy === 1'b1, "R2 busy mid block", 64'(busy), 64'h1);
        wait_done();
        ct = dout;
        issue_exp(KEY1, ct, 1'b1, 1'b0, PT1, "R8 roundtrip set0");
        wait_done();

        issue(KEY1, PT2, 1'b1, 1'b0, "R5 dec set0");
        wait_done();
        issue(KEY2, PT1, 1'b0, 1'b1, "R7 enc set1");
        wait_done();
        ct = dout;
        issue_exp(KEY2, ct, 1'b1, 1'b1, PT1, "R8 roundtrip set1");
        wait_done();
        issue(KEY2, PT2, 1'b1, 1'b1, "R5 R7 dec set1");
        wait_done();

        // R11: output holds after done
        held = dout;
        repeat (6) @(negedge clk);
        check(dout === held && done === 1'b0, "R11 dout holds", dout, held);

        // R9: start while busy ignored
        issue(KEY2, PT1 ^ 64'h5A5A, 1'b0, 1'b0, "R9 in-flight result");
        repeat (10) @(negedge clk);
        key = KEY1; din = PT2; decrypt = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (40) @(negedge clk);
        check(sbq.size() == 0 && busy === 1'b0, "R9 no extra block", 64'(sbq.size()), 64'h0);

        // R12: back-to-back starts in the done cycle
        @(negedge clk);
        issue(KEY1, 64'h8000000000000000, 1'b0, 1'b1, "R12 first");
        wait_done();
        issue(KEY2, 64'h0000000000000001, 1'b1, 1'b0, "R12 second");
        wait_done();
        issue(KEY1, 64'hA5A5A5A5C3C3C3C3, 1'b0, 1'b0, "R12 third");
        wait_done();
        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R12 all drained", 64'(sbq.size()), 64'h0);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule